// File: doc/BRIEF.md
# Two-Level Interrupt Status Hub

This block gathers event indications from four identical data-path modules and presents them to a byte-wide microprocessor port. Each module owns one secondary status register and one enable register. Four event kinds per module latch into sticky status bits: a capture event and an insert event for each of the two traffic directions. Software clears these bits by writing ones to them. A fifth status bit mirrors a level from the module's performance monitor, and software cannot clear it.

For each module, the block ANDs every status bit with its enable bit and ORs the results. That gives one bit per module in a read-only primary summary register. A single interrupt line is the OR of those summary bits. Software reads the primary register to find the modules that need service, then reads the secondary register of each one, then clears what it has handled.

Top module: `irq_hub`

## Requirements
- R1: While reset is asserted and just after it is released, every status and enable bit, the read data and the interrupt output are 0.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge, and the bit stays set. For module m (A=0 to D=3), the status register is at address 0x24+m. Bit 0 is fwd-capture, bit 1 rev-capture, bit 2 fwd-insert and bit 3 rev-insert.
- R3: A write to a status register clears each event bit (bits 3:0) whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: If an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 4 follows the module's performance-monitor level input, one clock later. Writes to bit 4 have no effect.
- R6: The enable register for module m is at address 0x28+m. It is read/write on bits 4:0, which line up with the status bits.
- R7: Reserved bits 7:5 of the status and enable registers read as 0, and writes to them are ignored.
- R8: The primary register at 0x2C holds, in bit m, the OR over bits 4:0 of (status AND enable) for module m. Its bits 7:4 are 0. It is read-only, so writes to it change nothing.
- R9: The interrupt output is 1 exactly when some bit of the primary register is 1.
- R10: Read data appears one cycle after the read strobe is sampled and shows the register values from before any write in that same cycle. Reads of unmapped addresses return 0, and the read data is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_fwd_evt | input | 4 | Forward capture event pulse, one bit per module |
| cap_rev_evt | input | 4 | Reverse capture event pulse, one bit per module |
| ins_fwd_evt | input | 4 | Forward insert event pulse, one bit per module |
| ins_rev_evt | input | 4 | Reverse insert event pulse, one bit per module |
| perf_lvl | input | 4 | Performance-monitor pending level, one bit per module |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as an event pulse on the same bit. A write with only partial ones next to live bits is nearly as hard, since it must clear some bits and keep others. Directed sequences first set known bits, then issue the write with a pulse in the same cycle on a chosen bit. Read-back then shows that the bit survived and its neighbours were cleared. A long random phase follows, drawing addresses near the mapped window, sparse pulses and frequent writes. A behavioural model checks every cycle, so overlaps of this kind also occur by chance, across all four modules.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int EVT_BITS  = 5;  // four sticky events plus the monitor level
    localparam int STICKY    = 4;

    typedef struct packed {
        logic [EVT_BITS-1:0] st;
        logic [EVT_BITS-1:0] en;
    } slice_regs_t;
endpackage

// File: rtl/irq_slice.sv
module irq_slice
    import irq_hub_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_wr,
    input  logic                en_wr,
    input  logic [DW-1:0]       wdata,
    input  logic [STICKY-1:0]   evt_set,
    input  logic                perf_lvl,
    output logic [DW-1:0]       st_rd,
    output logic [DW-1:0]       en_rd,
    output logic                active
);
    localparam int PAD = DW - EVT_BITS;

    slice_regs_t regs_d, regs_q;

    always_comb begin
        logic [STICKY-1:0] clr_mask;
        regs_d   = regs_q;
        clr_mask = st_wr ? wdata[STICKY-1:0] : '0;
        // set pulses take priority over a clear in the same cycle
        regs_d.st[STICKY-1:0] = (regs_q.st[STICKY-1:0] & ~clr_mask) | evt_set;
        regs_d.st[EVT_BITS-1] = perf_lvl;
        if (en_wr) begin
            regs_d.en = wdata[EVT_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign st_rd  = {{PAD{1'b0}}, regs_q.st};
    assign en_rd  = {{PAD{1'b0}}, regs_q.en};
    assign active = |(regs_q.st & regs_q.en);

    // R2: a pulse leaves its bit set after the edge
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd[STICKY-1:0] & $past(evt_set)) == $past(evt_set));

    // R3: an event bit only falls when a one was written to it
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_rd[STICKY-1:0]) & ~st_rd[STICKY-1:0]
            & ~($past(st_wr) ? $past(wdata[STICKY-1:0]) : {STICKY{1'b0}})) == '0);

    // R5: monitor bit tracks its level one cycle later
    a_r5_perf_follows: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd[EVT_BITS-1] == $past(perf_lvl));
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
    parameter int         N_MOD     = 4,
    parameter int         DW        = 8,
    parameter int         AW        = 8,
    parameter logic [7:0] ST_BASE   = 8'h24,
    parameter logic [7:0] EN_BASE   = 8'h28,
    parameter logic [7:0] PRIM_ADDR = 8'h2C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  logic [AW-1:0]       addr,
    input  logic [N_MOD*DW-1:0] st_flat,
    input  logic [N_MOD*DW-1:0] en_flat,
    input  logic [DW-1:0]       prim,
    output logic [DW-1:0]       rdata
);
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd) begin
            if (addr == AW'(PRIM_ADDR)) begin
                rdata_d = prim;
            end
            for (int m = 0; m < N_MOD; m++) begin
                if (addr == AW'(ST_BASE) + AW'(m)) rdata_d = st_flat[m*DW +: DW];
                if (addr == AW'(EN_BASE) + AW'(m)) rdata_d = en_flat[m*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R10: no read last cycle means zero read data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd) |-> rdata == '0);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int         N_MOD     = 4,
    parameter int         DW        = 8,
    parameter int         AW        = 8,
    parameter logic [7:0] ST_BASE   = 8'h24,
    parameter logic [7:0] EN_BASE   = 8'h28,
    parameter logic [7:0] PRIM_ADDR = 8'h2C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_MOD-1:0] cap_fwd_evt,
    input  logic [N_MOD-1:0] cap_rev_evt,
    input  logic [N_MOD-1:0] ins_fwd_evt,
    input  logic [N_MOD-1:0] ins_rev_evt,
    input  logic [N_MOD-1:0] perf_lvl,
    output logic             irq_out
);
    localparam int PRIM_PAD = DW - N_MOD;

    logic [N_MOD*DW-1:0] st_flat, en_flat;
    logic [N_MOD-1:0]    mod_active;
    logic [DW-1:0]       prim;

    for (genvar g = 0; g < N_MOD; g++) begin : g_mod
        logic st_hit, en_hit;
        assign st_hit = bus_wr && (bus_addr == AW'(ST_BASE) + AW'(g));
        assign en_hit = bus_wr && (bus_addr == AW'(EN_BASE) + AW'(g));

        irq_slice #(.DW(DW)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .st_wr    (st_hit),
            .en_wr    (en_hit),
            .wdata    (bus_wdata),
            .evt_set  ({ins_rev_evt[g], ins_fwd_evt[g], cap_rev_evt[g], cap_fwd_evt[g]}),
            .perf_lvl (perf_lvl[g]),
            .st_rd    (st_flat[g*DW +: DW]),
            .en_rd    (en_flat[g*DW +: DW]),
            .active   (mod_active[g])
        );
    end

    assign prim    = {{PRIM_PAD{1'b0}}, mod_active};
    assign irq_out = |mod_active;

    irq_rd_mux #(
        .N_MOD(N_MOD), .DW(DW), .AW(AW),
        .ST_BASE(ST_BASE), .EN_BASE(EN_BASE), .PRIM_ADDR(PRIM_ADDR)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .st_flat (st_flat),
        .en_flat (en_flat),
        .prim    (prim),
        .rdata   (bus_rdata)
    );

    // R9: an interrupt requires some set status bit somewhere
    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|st_flat));

    // R8: a module with nothing enabled contributes no interrupt
    a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0) |-> !irq_out);

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && ($past(bus_addr) < AW'(ST_BASE) || $past(bus_addr) > AW'(PRIM_ADDR)))
            |-> bus_rdata == '0);
endmodule

// File: tb/irq_hub_test.sv
`timescale 1ns/1ps
module irq_hub_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] cap_fwd_evt = '0, cap_rev_evt = '0, ins_fwd_evt = '0, ins_rev_evt = '0;
    logic [3:0] perf_lvl = '0;
    logic       irq_out;

    always #2 clk = ~clk;

    irq_hub uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_fwd_evt(cap_fwd_evt), .cap_rev_evt(cap_rev_evt),
        .ins_fwd_evt(ins_fwd_evt), .ins_rev_evt(ins_rev_evt),
        .perf_lvl(perf_lvl), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_st[4];
    int m_en[4];
    int m_rdata = 0;
    int m_irq = 0;

    function automatic int prim_val();
        int p = 0;
        for (int m = 0; m < 4; m++) if ((m_st[m] & m_en[m]) != 0) p |= (1 << m);
        return p;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        int a;
        int rv;
        @(posedge clk);
        a = int'(bus_addr);
        rv = 0;
        if (bus_rd) begin
            if (a >= 'h24 && a <= 'h27) rv = m_st[a - 'h24];
            else if (a >= 'h28 && a <= 'h2B) rv = m_en[a - 'h28];
            else if (a == 'h2C) rv = prim_val();
        end
        m_rdata = rv;
        for (int m = 0; m < 4; m++) begin
            int clr = 0;
            int setv;
            if (bus_wr && a == 'h24 + m) clr = int'(bus_wdata) & 'hF;
            setv = int'(cap_fwd_evt[m]) | (int'(cap_rev_evt[m]) << 1)
                 | (int'(ins_fwd_evt[m]) << 2) | (int'(ins_rev_evt[m]) << 3);
            m_st[m] = ((m_st[m] & 'hF & ~clr) | setv) | (int'(perf_lvl[m]) << 4);
            if (bus_wr && a == 'h28 + m) m_en[m] = int'(bus_wdata) & 'h1F;
        end
        m_irq = (prim_val() != 0) ? 1 : 0;
        @(negedge clk);
        check(tag, int'(bus_rdata), m_rdata, "rdata");
        check((tag == "R10") ? "R9" : tag, int'(irq_out), m_irq, "irq_out");
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0;
        cap_fwd_evt = '0; cap_rev_evt = '0; ins_fwd_evt = '0; ins_rev_evt = '0;
    endtask

    task automatic rd_reg(input string tag, input int addr);
        idle(); bus_addr = 8'(addr); bus_rd = 1; step(tag);
        idle(); step(tag);
    endtask

    task automatic wr_reg(input string tag, input int addr, input int data);
        idle(); bus_addr = 8'(addr); bus_wdata = 8'(data); bus_wr = 1; step(tag);
        idle(); step(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 4; m++) begin m_st[m] = 0; m_en[m] = 0; end
        repeat (3) @(negedge clk);
        check("R1", int'(bus_rdata), 0, "rdata in reset");
        check("R1", int'(irq_out), 0, "irq in reset");
        rst_n = 1;
        step("R1");
        for (int a = 'h24; a <= 'h2C; a++) rd_reg("R1", a);

        // R2: each event kind on each module
        for (int m = 0; m < 4; m++) begin
            idle(); cap_fwd_evt[m] = 1; step("R2");
            idle(); ins_rev_evt[m] = (m % 2 == 1); cap_rev_evt[m] = (m % 2 == 0); step("R2");
            rd_reg("R2", 'h24 + m);
        end
        idle(); ins_fwd_evt = 4'b1010; step("R2");
        for (int m = 0; m < 4; m++) rd_reg("R2", 'h24 + m);

        // R6/R7: enable registers, reserved bits
        wr_reg("R6", 'h28, 'h01);
        wr_reg("R7", 'h29, 'hFF);
        rd_reg("R6", 'h28); rd_reg("R7", 'h29);
        rd_reg("R8", 'h2C);
        wr_reg("R7", 'h25, 'hE0);
        rd_reg("R7", 'h25);

        // R3: partial clears
        wr_reg("R3", 'h24, 'h00);
        rd_reg("R3", 'h24);
        wr_reg("R3", 'h24, 'h01);
        rd_reg("R3", 'h24);
        rd_reg("R9", 'h2C);
        wr_reg("R3", 'h25, 'h0F);
        rd_reg("R3", 'h25);

        // R4: set wins over clear on the same bit
        idle(); cap_fwd_evt[2] = 1; cap_rev_evt[2] = 1; step("R4");
        idle(); bus_addr = 8'h26; bus_wdata = 8'h0F; bus_wr = 1; cap_rev_evt[2] = 1; step("R4");
        rd_reg("R4", 'h26);

        // R5: monitor bit follows level, write has no effect
        perf_lvl = 4'b0100; step("R5");
        wr_reg("R5", 'h26, 'h10);
        rd_reg("R5", 'h26);
        wr_reg("R6", 'h2A, 'h10);
        rd_reg("R8", 'h2C);
        perf_lvl = 4'b0000; step("R5");
        rd_reg("R9", 'h2C);

        // R8: primary is read-only; R10: unmapped and read/write same cycle
        wr_reg("R8", 'h2C, 'hFF);
        rd_reg("R8", 'h2C);
        rd_reg("R10", 'h23); rd_reg("R10", 'h2D); rd_reg("R10", 'hFF);
        idle(); bus_addr = 8'h28; bus_wdata = 8'h1F; bus_wr = 1; bus_rd = 1; step("R10");
        rd_reg("R10", 'h28);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle();
            bus_addr  = 8'('h22 + ($urandom % 13));
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_rd    = ($urandom % 2) == 0;
            cap_fwd_evt = 4'($urandom & $urandom & $urandom);
            cap_rev_evt = 4'($urandom & $urandom & $urandom);
            ins_fwd_evt = 4'($urandom & $urandom & $urandom);
            ins_rev_evt = 4'($urandom & $urandom & $urandom);
            if (($urandom % 8) == 0) perf_lvl = 4'($urandom);
            step("R3");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule